// File: doc/BRIEF.md
# DMA Channel Burst Transfer Sequencer

This block paces the item transfers of one DMA channel. A packed control word, presented with a single-cycle start pulse, supplies four things: the source and destination item sizes, a power-of-two arbitration code, the number of items minus one, and a flag for the final remainder. Once a start is accepted, the block raises a transfer request. Each cycle in which that request meets a grant moves one item.

Items move in runs. The length of a run is set by the arbitration code. When a run ends and items are still left, the block does two things in order. First it holds its request low for one cycle and publishes the outstanding count in the field format (items minus one). Then it pulses a re-arbitration strobe for one cycle, so that a channel arbiter can step in before the next run begins. A tail shorter than a full run is sent as single transfers, or as one burst when the flag is set. The block pulses done when the last item has moved, and then waits for the next start.

A configuration that is illegal is rejected at start with a one-cycle error pulse. Address generation and bus protocol are left to the surrounding logic; the request/grant pair stands in for the bus.

Top module: `dma_run_seq`

## Requirements
- R1: While reset is applied and after it is released, the block drives `req_o`, `burst_o`, `wb_valid_o`, `wb_count_o`, `rearb_o`, `done_o`, `cfg_err_o` and `item_size_o` to zero.
- R2: The control word has this layout: source size at bits [1:0], destination size at [3:2], arbitration code at [7:4], item count minus one at [17:8], final-burst flag at bit 18. The size codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for reserved. A start with source size 3 makes `cfg_err_o` high for exactly the one cycle after the start edge, and no request follows.
- R3: A start whose source size and destination size differ is rejected in the same way as in R2: a one-cycle `cfg_err_o` pulse and no request.
- R4: An arbitration code c from 0 to 9 gives full runs of exactly 2^c transfers. Between consecutive runs there is a writeback followed by a re-arbitration.
- R5: Arbitration codes 10 to 15 all give a run length of 1024. No re-arbitration happens for any count.
- R6: A count field value v moves exactly v+1 items. The value 0 moves 1 item and 1023 moves 1024 items. The count is in items, whatever the item size.
- R7: At each arbitration point, `wb_valid_o` is high for one cycle with `wb_count_o` equal to the outstanding items minus one. In the following cycle `rearb_o` is high for one cycle. `req_o` is low in both cycles. After the final item there is neither a writeback nor a re-arbitration.
- R8: During a full-length run `burst_o` is high. When fewer items remain than the run length and the flag is clear, the remainder goes as single transfers: `burst_o` is low and there is no re-arbitration inside the remainder.
- R9: When the final-burst flag is set, the short remainder goes out with `burst_o` high.
- R10: Exactly one item moves in each cycle where `req_o` and `grant_i` are both high at a clock edge. A grant that arrives while no request is raised has no effect.
- R11: After the edge that moves the last item, `done_o` is high for exactly one cycle. At that point the block is idle and `req_o` is low.
- R12: A start pulse that arrives while a transfer is in progress is ignored. It neither changes the item count nor causes a second done.
- R13: After an accepted start, `item_size_o` shows the accepted size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start strobe |
| ctrl_i | input | 19 | Packed control word (layout in R2) |
| grant_i | input | 1 | Grant for the current item request |
| req_o | output | 1 | Item transfer request |
| burst_o | output | 1 | High while the current run is a burst |
| wb_valid_o | output | 1 | Writeback strobe of the outstanding count |
| wb_count_o | output | 10 | Outstanding items minus one |
| rearb_o | output | 1 | Re-arbitration point strobe |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | One-cycle configuration error pulse |
| item_size_o | output | 2 | Latched item size code |

## Verification
The assertions take for granted that `rst_n` is applied before any start and that a grant is meaningful only while a request is raised. They also assume the surrounding arbiter does not have to answer the re-arbitration strobe, since the block resumes by itself one cycle later. The stimulus always opens with a reset. Grants come either on every requesting cycle or on every other cycle. In one scenario the grant is held high while the block is idle, so that a stray grant can be shown to have no effect. Start strobes last exactly one cycle and are changed only on the falling edge.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   // Item size encoding carried in the control word
   typedef enum logic [1:0] {
      ISZ_8    = 2'd0,
      ISZ_16   = 2'd1,
      ISZ_32   = 2'd2,
      ISZ_RSVD = 2'd3
   } item_size_e;

   localparam int unsigned ISZ_W = 2;

   // Sequencer states
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_WB   = 2'd2,
      SQ_ARB  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
   import dma_seq_pkg::*;
#(
   parameter int unsigned ARB_W = 4,
   parameter int unsigned CNT_W = 10,
   localparam int unsigned CW   = 2*ISZ_W + ARB_W + CNT_W + 1
) (
   input  logic [CW-1:0]    ctrl_i,
   output item_size_e       size_o,
   output logic [ARB_W-1:0] arb_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fin_burst_o,
   output logic             err_o
);

   localparam int unsigned SRC_LO = 0;
   localparam int unsigned DST_LO = SRC_LO + ISZ_W;
   localparam int unsigned ARB_LO = DST_LO + ISZ_W;
   localparam int unsigned CNT_LO = ARB_LO + ARB_W;
   localparam int unsigned FLG_BIT = CNT_LO + CNT_W;

   logic [ISZ_W-1:0] src_sz;
   logic [ISZ_W-1:0] dst_sz;

   always_comb begin
      src_sz      = ctrl_i[SRC_LO +: ISZ_W];
      dst_sz      = ctrl_i[DST_LO +: ISZ_W];
      arb_o       = ctrl_i[ARB_LO +: ARB_W];
      cnt_o       = ctrl_i[CNT_LO +: CNT_W];
      fin_burst_o = ctrl_i[FLG_BIT];
      size_o      = item_size_e'(src_sz);
      err_o       = (src_sz == ISZ_RSVD) || (src_sz != dst_sz);
   end

endmodule

// File: rtl/dma_run_len.sv
module dma_run_len #(
   parameter int unsigned ARB_W = 4,
   parameter int unsigned CNT_W = 10,
   localparam int unsigned REM_W = CNT_W + 1,
   localparam int unsigned NCODE = 1 << ARB_W
) (
   input  logic [ARB_W-1:0] code_i,
   output logic [REM_W-1:0] len_o
);

   localparam logic [REM_W-1:0] MAX_LEN = REM_W'(1) << CNT_W;

   if (ARB_W < 1 || ARB_W > 8) begin : g_bad_arb
      $error("dma_run_len: ARB_W out of range");
   end
   if (CNT_W < 1 || CNT_W > 20) begin : g_bad_cnt
      $error("dma_run_len: CNT_W out of range");
   end

   logic [REM_W-1:0] lut [NCODE];

   // Codes up to CNT_W-1 give a power of two; larger codes saturate at the maximum count
   for (genvar k = 0; k < NCODE; k++) begin : g_code
      if (k < CNT_W) begin : g_pow
         assign lut[k] = REM_W'(1) << k;
      end else begin : g_sat
         assign lut[k] = MAX_LEN;
      end
   end

   assign len_o = lut[code_i];

endmodule

// File: rtl/dma_item_ctr.sv
module dma_item_ctr #(
   parameter int unsigned CNT_W = 10,
   localparam int unsigned REM_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_cnt_i,
   input  logic             seg_i,
   input  logic [REM_W-1:0] run_len_i,
   input  logic             hit_i,
   output logic             last_o,
   output logic             run_end_o,
   output logic             full_o,
   output logic [CNT_W-1:0] wb_cnt_o
);

   logic [REM_W-1:0] rem_q;
   logic [REM_W-1:0] run_q;
   logic             full_q;
   logic [REM_W-1:0] base;
   logic             base_full;

   always_comb begin
      base      = load_i ? ({1'b0, load_cnt_i} + REM_W'(1)) : rem_q;
      base_full = (base >= run_len_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         run_q  <= '0;
         full_q <= 1'b0;
      end else begin
         if (load_i) begin
            rem_q <= base;
         end else if (hit_i) begin
            rem_q <= rem_q - REM_W'(1);
         end
         if (seg_i) begin
            run_q  <= base_full ? run_len_i : base;
            full_q <= base_full;
         end else if (hit_i) begin
            run_q <= run_q - REM_W'(1);
         end
      end
   end

   always_comb begin
      last_o    = (rem_q == REM_W'(1));
      run_end_o = (run_q == REM_W'(1));
      full_o    = full_q;
      wb_cnt_o  = CNT_W'(rem_q - REM_W'(1));
   end

endmodule

// File: rtl/dma_run_seq.sv
module dma_run_seq
   import dma_seq_pkg::*;
#(
   parameter int unsigned ARB_W = 4,
   parameter int unsigned CNT_W = 10,
   localparam int unsigned CW    = 2*ISZ_W + ARB_W + CNT_W + 1,
   localparam int unsigned REM_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CW-1:0]    ctrl_i,
   input  logic             grant_i,
   output logic             req_o,
   output logic             burst_o,
   output logic             wb_valid_o,
   output logic [CNT_W-1:0] wb_count_o,
   output logic             rearb_o,
   output logic             done_o,
   output logic             cfg_err_o,
   output logic [ISZ_W-1:0] item_size_o
);

   seq_state_e       state_q;
   item_size_e       dec_size;
   logic [ARB_W-1:0] dec_arb;
   logic [CNT_W-1:0] dec_cnt;
   logic             dec_flag;
   logic             dec_err;

   logic [ARB_W-1:0] arb_q;
   logic             flag_q;
   item_size_e       size_q;
   logic             done_q;
   logic             err_q;

   logic [ARB_W-1:0] code_sel;
   logic [REM_W-1:0] run_len;
   logic             accept;
   logic             reject;
   logic             hit;
   logic             seg;
   logic             last_item;
   logic             run_end;
   logic             full_run;
   logic [CNT_W-1:0] wb_cnt;

   dma_cfg_decode #(.ARB_W(ARB_W), .CNT_W(CNT_W)) dec_i (
      .ctrl_i      (ctrl_i),
      .size_o      (dec_size),
      .arb_o       (dec_arb),
      .cnt_o       (dec_cnt),
      .fin_burst_o (dec_flag),
      .err_o       (dec_err)
   );

   always_comb begin
      accept   = (state_q == SQ_IDLE) && start_i && !dec_err;
      reject   = (state_q == SQ_IDLE) && start_i &&  dec_err;
      hit      = (state_q == SQ_RUN)  && grant_i;
      seg      = accept || (state_q == SQ_ARB);
      code_sel = (state_q == SQ_IDLE) ? dec_arb : arb_q;
   end

   dma_run_len #(.ARB_W(ARB_W), .CNT_W(CNT_W)) len_i (
      .code_i (code_sel),
      .len_o  (run_len)
   );

   dma_item_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_cnt_i (dec_cnt),
      .seg_i      (seg),
      .run_len_i  (run_len),
      .hit_i      (hit),
      .last_o     (last_item),
      .run_end_o  (run_end),
      .full_o     (full_run),
      .wb_cnt_o   (wb_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         arb_q   <= '0;
         flag_q  <= 1'b0;
         size_q  <= ISZ_8;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= hit && last_item;
         err_q  <= reject;
         unique case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  arb_q   <= dec_arb;
                  flag_q  <= dec_flag;
                  size_q  <= dec_size;
                  state_q <= SQ_RUN;
               end
            end
            SQ_RUN: begin
               if (hit) begin
                  if (last_item) begin
                     state_q <= SQ_IDLE;
                  end else if (run_end) begin
                     state_q <= SQ_WB;
                  end
               end
            end
            SQ_WB:   state_q <= SQ_ARB;
            SQ_ARB:  state_q <= SQ_RUN;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      req_o       = (state_q == SQ_RUN);
      burst_o     = req_o && (full_run || flag_q);
      wb_valid_o  = (state_q == SQ_WB);
      wb_count_o  = wb_valid_o ? wb_cnt : '0;
      rearb_o     = (state_q == SQ_ARB);
      done_o      = done_q;
      cfg_err_o   = err_q;
      item_size_o = size_q;
   end

endmodule

// File: rtl/dma_run_seq_chk.sv
module dma_run_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_o,
   input logic burst_o,
   input logic wb_valid_o,
   input logic rearb_o,
   input logic done_o,
   input logic cfg_err_o
);

   // R7
   wb_then_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |=> (rearb_o && !req_o));

   // R7
   arb_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rearb_o |-> $past(wb_valid_o));

   // R7
   phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_o, wb_valid_o, rearb_o}));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!req_o && !wb_valid_o && !rearb_o));

   // R2
   err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> (!req_o && !done_o));

   // R2
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |=> !cfg_err_o);

   // R8
   burst_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && $past(req_o)) |-> $stable(burst_o));

   // R1
   burst_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_o |-> req_o);

endmodule

bind dma_run_seq dma_run_seq_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_o      (req_o),
   .burst_o    (burst_o),
   .wb_valid_o (wb_valid_o),
   .rearb_o    (rearb_o),
   .done_o     (done_o),
   .cfg_err_o  (cfg_err_o)
);

// File: tb/dma_run_seq_tb_top.sv
module dma_run_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [18:0] ctrl_i = '0;
   logic        grant_i = 1'b0;
   logic        req_o, burst_o, wb_valid_o, rearb_o, done_o, cfg_err_o;
   logic [9:0]  wb_count_o;
   logic [1:0]  item_size_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // monitor state
   int gmode = 0;       // 0 grant on every request, 1 every other cycle, 2 always high
   bit tog = 1'b0;
   int obs_items, obs_wb, obs_rearb, obs_done, burst_bad;
   bit exp_burst [1024];
   int exp_wb [1024];
   int exp_nwb;

   dma_run_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_i(ctrl_i),
      .grant_i(grant_i), .req_o(req_o), .burst_o(burst_o),
      .wb_valid_o(wb_valid_o), .wb_count_o(wb_count_o), .rearb_o(rearb_o),
      .done_o(done_o), .cfg_err_o(cfg_err_o), .item_size_o(item_size_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WATCHDOG) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
         summary();
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [18:0] pack(input int src, input int dst, input int arb,
                                        input int cnt, input bit flag);
      return {flag, cnt[9:0], arb[3:0], dst[1:0], src[1:0]};
   endfunction

   // Monitor and grant driver: observes outputs and sets the grant on the falling edge
   always @(negedge clk) begin
      bit g;
      tog = ~tog;
      g = (gmode == 2) ? 1'b1 : (req_o && (gmode == 0 || tog));
      grant_i = g;
      if (req_o && g) begin
         if (obs_items < 1024 && burst_o != exp_burst[obs_items]) begin
            burst_bad = burst_bad + 1;
            $display("FAIL R8/R9 burst at item %0d: actual %0d expected %0d",
                     obs_items, burst_o, exp_burst[obs_items]);
         end
         obs_items = obs_items + 1;
      end
      if (wb_valid_o) begin
         if (obs_wb < exp_nwb) chk(int'(wb_count_o) == exp_wb[obs_wb], "R7 writeback value",
                                    int'(wb_count_o), exp_wb[obs_wb]);
         else chk(1'b0, "R7 unexpected writeback", obs_wb, exp_nwb);
         obs_wb = obs_wb + 1;
      end
      if (rearb_o)  obs_rearb = obs_rearb + 1;
      if (done_o)   obs_done  = obs_done + 1;
   end

   task automatic clear_obs();
      obs_items = 0; obs_wb = 0; obs_rearb = 0; obs_done = 0; burst_bad = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!req_o && !burst_o && !wb_valid_o && !rearb_o && !done_o && !cfg_err_o
          && wb_count_o == 0 && item_size_o == 0, "R1 outputs in reset",
          {req_o, burst_o, wb_valid_o, rearb_o, done_o, cfg_err_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!req_o && !done_o && !cfg_err_o && item_size_o == 0, "R1 outputs after reset",
          {req_o, done_o, cfg_err_o}, 0);
   endtask

   // Runs one transfer, builds the expected picture from the requirements and compares
   task automatic run_case(input string tag, input int size, input int arb, input int cnt,
                           input bit flag, input int gm, input bit inject);
      int n, len, rem, idx, c;
      n = cnt + 1;
      len = (arb >= 10) ? 1024 : (1 << arb);
      rem = n; idx = 0; exp_nwb = 0;
      while (rem > 0) begin
         if (rem >= len) begin
            for (int i = 0; i < len; i++) begin exp_burst[idx] = 1'b1; idx++; end
            rem = rem - len;
            if (rem > 0) begin exp_wb[exp_nwb] = rem - 1; exp_nwb++; end
         end else begin
            for (int i = 0; i < rem; i++) begin exp_burst[idx] = flag; idx++; end
            rem = 0;
         end
      end
      clear_obs();
      gmode = gm;
      @(negedge clk);
      ctrl_i = pack(size, size, arb, cnt, flag);
      start_i = 1'b1;
      c = 0;
      do begin
         @(negedge clk);
         start_i = (inject && c == 4);
         if (inject && c == 4) ctrl_i = pack(0, 0, 0, 0, 1'b0);
         if (c == 1) chk(int'(item_size_o) == size, {tag, " R13 size latched"},
                         int'(item_size_o), size);
         c++;
      end while (obs_done == 0 && c < 5000);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      chk(obs_items == n, {tag, " R6 item count"}, obs_items, n);
      chk(obs_rearb == exp_nwb, {tag, " R4/R5 rearbitration count"}, obs_rearb, exp_nwb);
      chk(obs_wb == exp_nwb, {tag, " R7 writeback count"}, obs_wb, exp_nwb);
      chk(burst_bad == 0, {tag, " R8 burst pattern"}, burst_bad, 0);
      chk(obs_done == 1, {tag, " R11 single done pulse"}, obs_done, 1);
      chk(!req_o, {tag, " R11 idle after done"}, req_o, 0);
      if (inject) chk(obs_items == n && obs_done == 1, {tag, " R12 start while busy ignored"},
                      obs_items, n);
      gmode = 0;
   endtask

   task automatic err_case(input string tag, input int src, input int dst);
      clear_obs();
      @(negedge clk);
      ctrl_i = pack(src, dst, 1, 5, 1'b0);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(cfg_err_o == 1'b1, {tag, " error pulse"}, cfg_err_o, 1);
      chk(!req_o, {tag, " no request"}, req_o, 0);
      @(negedge clk);
      chk(cfg_err_o == 1'b0 && !req_o, {tag, " error pulse ends"}, cfg_err_o, 0);
      repeat (3) @(negedge clk);
      chk(obs_items == 0 && obs_done == 0, {tag, " nothing moved"}, obs_items, 0);
   endtask

   task automatic idle_grant_case();
      clear_obs();
      gmode = 2;
      repeat (6) @(negedge clk);
      chk(!req_o && obs_done == 0 && !wb_valid_o, "R10 grant while idle ignored",
          obs_done, 0);
      gmode = 0;
      run_case("R10 after idle grants", 0, 3, 1, 1'b0, 0, 1'b0);
   endtask

   initial begin
      t_reset();
      err_case("R2 reserved size", 3, 3);
      err_case("R3 size mismatch", 1, 2);
      run_case("R4 arb0", 2, 0, 2, 1'b0, 0, 1'b0);
      run_case("R4 arb2 singles", 1, 2, 9, 1'b0, 0, 1'b0);
      run_case("R9 arb2 final burst", 1, 2, 9, 1'b1, 1, 1'b0);
      run_case("R4 arb3 exact", 0, 3, 15, 1'b0, 1, 1'b0);
      run_case("R6 single item", 2, 4, 0, 1'b0, 0, 1'b0);
      run_case("R5 arb12 full", 2, 12, 1023, 1'b0, 0, 1'b0);
      run_case("R5 arb10 partial", 0, 10, 599, 1'b0, 0, 1'b0);
      run_case("R4 arb9 max", 1, 9, 1023, 1'b0, 0, 1'b0);
      run_case("R12 busy start", 0, 2, 19, 1'b0, 0, 1'b1);
      idle_grant_case();
      summary();
   end

endmodule